// File: doc/BRIEF.md
# Narrow-Port Long-Word Write Packer

This block sits between a narrow write port and a 36-bit FIFO that only accepts whole long words. The port carries either 9-bit bytes or 18-bit words, chosen by a static size input. Each piece accepted on a clock edge is placed into auxiliary holding registers. The edge that accepts the last piece of a long word (the fourth byte or the second word) also pushes the complete 36-bit word into the FIFO, with the final piece merged straight from the port.

Piece placement follows an ordering mode. In big-endian order the first piece fills the most significant lanes. In little-endian order it fills the least significant lanes. Both the size and the ordering are sampled while reset is held and are then frozen until the next reset. Input-ready drops whenever the FIFO reports full and the next piece would complete a word, so a piece is never accepted without room for it.

Top module: `narrow_wr_packer`

## Requirements
- R1: `rst` is synchronous and active high. While `rst` is high, `in_ready` is 0 after each clock edge. After the first edge with `rst` low, `in_ready` is 1, provided the FIFO is not full, and the next accepted piece is the first piece of a new long word.
- R2: With `size_byte`=0 (18-bit words) and `order_big`=1, the first word goes to bits [35:18] and the second word to bits [17:0].
- R3: With `size_byte`=0 and `order_big`=0, the first word goes to bits [17:0] and the second word to bits [35:18].
- R4: With `size_byte`=1 (9-bit bytes) and `order_big`=1, bytes one to four go to bits [35:27], [26:18], [17:9] and [8:0] in that order.
- R5: With `size_byte`=1 and `order_big`=0, bytes one to four go to bits [8:0], [17:9], [26:18] and [35:27] in that order.
- R6: `push` is 1 only in the cycle whose edge accepts the final piece of a word, and `push_data` is valid in that same cycle. Earlier pieces do not push, and long words follow each other back to back.
- R7: In byte mode, `wr_data[17:9]` has no effect on the packed word.
- R8: When `fifo_full` is 1 and the next piece would complete a word, `in_ready` is 0. When the next piece would not complete a word, `in_ready` stays 1 even if `fifo_full` is 1.
- R9: If `wr_en` is high while `in_ready` is 0, the piece is ignored: the word position does not advance and nothing is stored.
- R10: `size_byte` and `order_big` are sampled only while `rst` is high. Changing them after reset has no effect on packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while it is high |
| size_byte | input | 1 | 1 = 9-bit byte pieces, 0 = 18-bit word pieces |
| order_big | input | 1 | 1 = first piece most significant, 0 = first piece least significant |
| wr_en | input | 1 | Port write enable |
| wr_data | input | 18 | Port data; only [8:0] is used in byte mode |
| in_ready | output | 1 | Port may accept a piece this cycle |
| push | output | 1 | FIFO write strobe for a complete long word |
| push_data | output | 36 | Packed long word |
| fifo_full | input | 1 | FIFO has no room for a long word |

## Verification
The assertions assume that `fifo_full` reflects the FIFO's state before the current edge. They also assume that the configuration inputs are meaningful only while reset is held. A push is therefore expected never to coincide with a full indication, and the latched configuration is expected to stay constant outside reset. The stimulus changes `size_byte` and `order_big` only during reset, except in the one test that changes them on purpose after reset to show that the change is ignored. The stimulus raises `fifo_full` only between pushes, as a FIFO would, and drives all inputs half a cycle away from the sampling edge.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int LANE_W  = 9;
    localparam int LANES   = 4;
    localparam int PORT_W  = 2 * LANE_W;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int SLOT_W  = $clog2(LANES);

    typedef enum logic { SZ_WORD = 1'b0, SZ_BYTE = 1'b1 } size_e;
    typedef enum logic { ORD_LITTLE = 1'b0, ORD_BIG = 1'b1 } order_e;

    typedef struct packed {
        size_e  size;
        order_e order;
    } cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] val;
        logic [WORD_W-1:0] mask;
    } piece_t;

    function automatic logic [SLOT_W-1:0] final_slot(cfg_t c);
        return (c.size == SZ_BYTE) ? SLOT_W'(LANES - 1) : SLOT_W'(LANES / 2 - 1);
    endfunction

    function automatic piece_t place(cfg_t c, logic [SLOT_W-1:0] slot,
                                     logic [PORT_W-1:0] d);
        piece_t p;
        int     pos;
        if (c.size == SZ_BYTE) begin
            pos    = (c.order == ORD_BIG) ? (LANES - 1 - int'(slot)) : int'(slot);
            p.val  = WORD_W'(d[LANE_W-1:0]) << (pos * LANE_W);
            p.mask = WORD_W'({LANE_W{1'b1}}) << (pos * LANE_W);
        end else begin
            pos    = (c.order == ORD_BIG) ? (1 - int'(slot[0])) : int'(slot[0]);
            p.val  = WORD_W'(d) << (pos * PORT_W);
            p.mask = WORD_W'({PORT_W{1'b1}}) << (pos * PORT_W);
        end
        return p;
    endfunction

endpackage

// File: rtl/wp_cfg_latch.sv
module wp_cfg_latch
    import wp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic size_in,
    input  logic order_in,
    output cfg_t cfg_q,
    output logic ready_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.size  <= size_e'(size_in);
            cfg_q.order <= order_e'(order_in);
            ready_q     <= 1'b0;
        end else begin
            ready_q     <= 1'b1;
        end
    end

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_q));

endmodule

// File: rtl/wp_slot_ctr.sv
module wp_slot_ctr
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              is_last,
    input  cfg_t              cfg,
    output logic [SLOT_W-1:0] slot
);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (accept)
            slot <= is_last ? '0 : slot + 1'b1;
    end

    // R6
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot <= final_slot(cfg));

    // R6
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !is_last) |=> slot == $past(slot) + 1'b1);

    // R9
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(slot));

endmodule

// File: rtl/wp_assembler.sv
module wp_assembler
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              is_last,
    input  cfg_t              cfg,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PORT_W-1:0] data,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] aux_q;
    piece_t            pc;

    always_comb begin
        pc   = place(cfg, slot, data);
        word = (aux_q & ~pc.mask) | pc.val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            aux_q <= '0;
        else if (accept)
            aux_q <= is_last ? '0 : word;
    end

    // R9
    aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(aux_q));

endmodule

// File: rtl/narrow_wr_packer.sv
module narrow_wr_packer
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              size_byte,
    input  logic              order_big,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output logic              in_ready,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    input  logic              fifo_full
);

    cfg_t              cfg;
    logic              ready_q;
    logic [SLOT_W-1:0] slot;
    logic              is_last;
    logic              accept;

    wp_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .size_in  (size_byte),
        .order_in (order_big),
        .cfg_q    (cfg),
        .ready_q  (ready_q)
    );

    wp_slot_ctr u_slot (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .is_last (is_last),
        .cfg     (cfg),
        .slot    (slot)
    );

    wp_assembler u_asm (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .is_last (is_last),
        .cfg     (cfg),
        .slot    (slot),
        .data    (wr_data),
        .word    (push_data)
    );

    always_comb begin
        is_last  = (slot == final_slot(cfg));
        in_ready = ready_q && !(fifo_full && is_last);
        accept   = wr_en && in_ready;
        push     = accept && is_last;
    end

    // R8
    push_room_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !fifo_full);

    // R1
    ready_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> slot == '0);

    // R6
    push_restart_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> slot == '0);

endmodule

// File: tb/narrow_wr_packer_tb.sv
module narrow_wr_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        size_byte, order_big, wr_en, fifo_full;
    logic [17:0] wr_data;
    logic        in_ready, push;
    logic [35:0] push_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    narrow_wr_packer dut_i (
        .clk       (clk),
        .rst       (rst),
        .size_byte (size_byte),
        .order_big (order_big),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .in_ready  (in_ready),
        .push      (push),
        .push_data (push_data),
        .fifo_full (fifo_full)
    );

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(bit sz, bit ord);
        @(negedge clk);
        rst = 1'b1; size_byte = sz; order_big = ord;
        wr_en = 1'b0; wr_data = '0; fifo_full = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 ready low in reset", 36'(in_ready), 36'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", 36'(in_ready), 36'd1);
    endtask

    // drive one piece at negedge, sample before the edge, then take the edge
    task automatic send(logic [17:0] d, bit exp_push, logic [35:0] exp_word, string req);
        wr_en = 1'b1; wr_data = d;
        #2;
        check({req, " push"}, 36'(push), 36'(exp_push));
        if (exp_push) check({req, " data"}, push_data, exp_word);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_word_big;
        do_reset(1'b0, 1'b1);
        send(18'h2ABCD, 1'b0, '0, "R2");
        send(18'h15678, 1'b1, {18'h2ABCD, 18'h15678}, "R2");
        send(18'h00111, 1'b0, '0, "R6");
        send(18'h3FFFF, 1'b1, {18'h00111, 18'h3FFFF}, "R6");
    endtask

    task automatic t_word_little;
        do_reset(1'b0, 1'b0);
        send(18'h2ABCD, 1'b0, '0, "R3");
        send(18'h15678, 1'b1, {18'h15678, 18'h2ABCD}, "R3");
    endtask

    task automatic t_byte_big;
        do_reset(1'b1, 1'b1);
        send({9'h1FF, 9'h101}, 1'b0, '0, "R7");
        send({9'h0AA, 9'h0C2}, 1'b0, '0, "R7");
        send({9'h155, 9'h033}, 1'b0, '0, "R7");
        send({9'h1C3, 9'h1E4}, 1'b1, {9'h101, 9'h0C2, 9'h033, 9'h1E4}, "R4");
    endtask

    task automatic t_byte_little;
        do_reset(1'b1, 1'b0);
        send(18'h00011, 1'b0, '0, "R5");
        send(18'h00122, 1'b0, '0, "R5");
        send(18'h00033, 1'b0, '0, "R5");
        send(18'h00144, 1'b1, {9'h144, 9'h033, 9'h122, 9'h011}, "R5");
    endtask

    task automatic t_full;
        do_reset(1'b1, 1'b1);
        fifo_full = 1'b1;
        #2 check("R8 ready while full, not final", 36'(in_ready), 36'd1);
        @(negedge clk);
        send(18'h00001, 1'b0, '0, "R8");
        send(18'h00002, 1'b0, '0, "R8");
        send(18'h00003, 1'b0, '0, "R8");
        #2 check("R8 ready low on final while full", 36'(in_ready), 36'd0);
        @(negedge clk);
        send(18'h000EE, 1'b0, '0, "R9");
        fifo_full = 1'b0;
        #2 check("R9 ready back after full clears", 36'(in_ready), 36'd1);
        @(negedge clk);
        send(18'h00004, 1'b1, {9'h001, 9'h002, 9'h003, 9'h004}, "R9");
    endtask

    task automatic t_cfg_frozen;
        do_reset(1'b0, 1'b0);
        size_byte = 1'b1; order_big = 1'b1;
        send(18'h12345, 1'b0, '0, "R10");
        send(18'h0ABCD, 1'b1, {18'h0ABCD, 18'h12345}, "R10");
    endtask

    initial begin
        rst = 1'b1; size_byte = 1'b0; order_big = 1'b0;
        wr_en = 1'b0; wr_data = '0; fifo_full = 1'b0;
        t_word_big();
        t_word_little();
        t_byte_big();
        t_byte_little();
        t_full();
        t_cfg_frozen();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule